// File: doc/BRIEF.md
# PSRAM Chip-Select Pulse Limiter

This block drives the active-low chip selects of four PSRAM banks on behalf of a synchronous burst engine. Some PSRAM devices require their chip select to return high at regular intervals so that they can refresh. The block enforces that limit. A single programmed limit is shared by all banks, and each bank has its own enable bit. When an enabled access has kept its chip select low for the programmed number of kernel clock cycles, the block breaks the burst. It raises the chip select, pauses the engine for a fixed minimum gap, and then restarts the access on the same bank. With the restart it hands back the address of the first beat that was not transferred.

The engine holds `accReq` high for as long as it wants the access to continue, and drops it to end the access. A configuration register holds the limit and the bank enables. Its value is taken into use only when a chip select falls. A write made during an access therefore governs only the next access or the next restart.

Top module: `psram_cs_limiter`

## Requirements
- R1: The configuration register reads back the limit in bits [15:0] and the enables of banks 0 to 3 in bits [16] to [19] (bit 16+b enables bank b). All other bits read zero, and the register is zero after reset.
- R2: At most one chip select is low at any time. An access started from idle uses the bank given by `accBank` in the cycle where `accReq` is first seen. That bank is kept for the whole access, including any restarts.
- R3: A limited access keeps its chip select low for exactly C consecutive cycles, where C is the limit taken at that falling edge, and then splits. The count is reloaded at every falling edge, including each restart.
- R4: An access is limited only if three conditions hold when its chip select falls: the enable bit of its bank is set, the limit is nonzero and `accSync` is high. Otherwise its chip select stays low for as long as `accReq` stays high, and `pause` never rises.
- R5: On a split, the chip select is high and `pause` is high for exactly MIN_GAP cycles (default 3). In the next cycle the same bank's chip select is low again and `resume` is high for one cycle. At that point `resumeAddr` equals `nextAddr` as sampled in the last low cycle before the split.
- R6: If `accReq` is low in a low cycle, the access ends and the chip select is high in the next cycle, without a pause. This holds even in the cycle where the count expires.
- R7: A register write made while a chip select is low does not change the current low period. It takes effect at the next falling edge, including a restart.
- R8: If `accReq` is dropped during a pause, the block returns to idle after the gap. There is no resume and no chip select goes low.
- R9: A chip select goes low in the cycle after `accReq` is first seen high in idle. It returns high in the cycle after `accReq` is seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Configuration write strobe |
| regWdata | input | 32 | Configuration write data |
| regRdata | output | 32 | Configuration readback |
| accReq | input | 1 | Engine wants the access to continue |
| accBank | input | 2 | Bank of the access being started |
| accSync | input | 1 | Access is a synchronous read or write |
| nextAddr | input | 24 | Address of the next untransferred beat |
| csN | output | 4 | Active-low bank chip selects |
| pause | output | 1 | Engine must hold its burst |
| resume | output | 1 | One-cycle restart pulse |
| resumeAddr | output | 24 | Beat address at which to restart |

## Verification
The bench targets the cycle in which the count expires while the engine is releasing the access. A design that gives expiry priority would emit a spurious pause and restart an access nobody wants. Writes are made in the middle of a low period to catch a design that reloads from the live register, which would shorten or stretch the current pulse. The pulse is measured again after a restart, which exposes a counter that is not reloaded there. Disabled banks, a zero limit and asynchronous accesses each confirm that no split happens. Abandoning the access during the gap confirms that a restart is not issued regardless.

// File: rtl/psram_cs_limiter_pkg.sv
package psram_cs_limiter_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_GAP  = 2'd2
  } phase_t;

  typedef struct packed {
    logic latchBank;
    logic loadCnt;
    logic decCnt;
    logic loadGap;
    logic decGap;
    logic capAddr;
  } strobe_t;
endpackage

// File: rtl/psram_cs_limiter_datapath.sv
module psram_cs_limiter_datapath
  import psram_cs_limiter_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 24,
  parameter int MIN_GAP   = 3,
  parameter int REG_W     = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [REG_W-1:0]     regWdata,
  output logic [REG_W-1:0]     regRdata,
  input  logic [$clog2(NUM_BANKS)-1:0] accBank,
  input  logic                 accSync,
  input  logic [ADDR_W-1:0]    nextAddr,
  input  strobe_t              stb,
  output logic [$clog2(NUM_BANKS)-1:0] bank,
  output logic                 cntAtOne,
  output logic                 limitOn,
  output logic                 gapDone,
  output logic [ADDR_W-1:0]    resumeAddr
);
  localparam int BANK_W  = $clog2(NUM_BANKS);
  localparam int FIELD_W = CNT_W + NUM_BANKS;
  localparam int GAP_W   = $clog2(MIN_GAP + 1);

  logic [CNT_W-1:0]     cfgCount;
  logic [NUM_BANKS-1:0] cfgEnable;
  logic [CNT_W-1:0]     cnt;
  logic [GAP_W-1:0]     gapCnt;
  logic [BANK_W-1:0]    selBank;

  // Configuration register; only the defined fields are stored.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgCount  <= '0;
      cfgEnable <= '0;
    end else if (regWe) begin
      cfgCount  <= regWdata[CNT_W-1:0];
      cfgEnable <= regWdata[FIELD_W-1:CNT_W];
    end
  end

  always_comb begin
    regRdata = '0;
    regRdata[CNT_W-1:0]       = cfgCount;
    regRdata[FIELD_W-1:CNT_W] = cfgEnable;
  end

  // A fresh access uses the requested bank, a restart keeps the held one.
  assign selBank = stb.latchBank ? accBank : bank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bank       <= '0;
      cnt        <= '0;
      limitOn    <= 1'b0;
      gapCnt     <= '0;
      resumeAddr <= '0;
    end else begin
      if (stb.latchBank) bank <= accBank;
      if (stb.loadCnt) begin
        cnt     <= cfgCount;
        limitOn <= (cfgCount != '0) && cfgEnable[selBank] && accSync;
      end else if (stb.decCnt && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
      if (stb.loadGap)     gapCnt <= GAP_W'(MIN_GAP - 1);
      else if (stb.decGap) gapCnt <= gapCnt - 1'b1;
      if (stb.capAddr) resumeAddr <= nextAddr;
    end
  end

  assign cntAtOne = (cnt == CNT_W'(1));
  assign gapDone  = (gapCnt == '0);
endmodule

// File: rtl/psram_cs_limiter_control.sv
module psram_cs_limiter_control
  import psram_cs_limiter_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 accReq,
  input  logic                 cntAtOne,
  input  logic                 limitOn,
  input  logic                 gapDone,
  input  logic [$clog2(NUM_BANKS)-1:0] bank,
  output strobe_t              stb,
  output logic [NUM_BANKS-1:0] csN,
  output logic                 pause,
  output logic                 resume
);
  phase_t phase, phaseNext;
  logic   resumeNext;

  always_comb begin
    stb        = '0;
    phaseNext  = phase;
    resumeNext = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (accReq) begin
          stb.latchBank = 1'b1;
          stb.loadCnt   = 1'b1;
          phaseNext     = PH_LOW;
        end
      end
      PH_LOW: begin
        // A normal end wins over expiry in the same cycle.
        if (!accReq) begin
          phaseNext = PH_IDLE;
        end else if (limitOn && cntAtOne) begin
          stb.loadGap = 1'b1;
          stb.capAddr = 1'b1;
          phaseNext   = PH_GAP;
        end else begin
          stb.decCnt = 1'b1;
        end
      end
      PH_GAP: begin
        if (!gapDone) begin
          stb.decGap = 1'b1;
        end else if (accReq) begin
          stb.loadCnt = 1'b1;
          resumeNext  = 1'b1;
          phaseNext   = PH_LOW;
        end else begin
          phaseNext = PH_IDLE;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      resume <= 1'b0;
    end else begin
      phase  <= phaseNext;
      resume <= resumeNext;
    end
  end

  always_comb begin
    csN = '1;
    if (phase == PH_LOW) csN[bank] = 1'b0;
  end

  assign pause = (phase == PH_GAP);
endmodule

// File: rtl/psram_cs_limiter.sv
module psram_cs_limiter
  import psram_cs_limiter_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 24,
  parameter int MIN_GAP   = 3,
  parameter int REG_W     = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [REG_W-1:0]     regWdata,
  output logic [REG_W-1:0]     regRdata,
  input  logic                 accReq,
  input  logic [$clog2(NUM_BANKS)-1:0] accBank,
  input  logic                 accSync,
  input  logic [ADDR_W-1:0]    nextAddr,
  output logic [NUM_BANKS-1:0] csN,
  output logic                 pause,
  output logic                 resume,
  output logic [ADDR_W-1:0]    resumeAddr
);
  strobe_t stb;
  logic [$clog2(NUM_BANKS)-1:0] bank;
  logic cntAtOne, limitOn, gapDone;

  psram_cs_limiter_datapath #(
    .NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .MIN_GAP(MIN_GAP), .REG_W(REG_W)
  ) dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .accBank(accBank), .accSync(accSync),
    .nextAddr(nextAddr), .stb(stb), .bank(bank), .cntAtOne(cntAtOne),
    .limitOn(limitOn), .gapDone(gapDone), .resumeAddr(resumeAddr)
  );

  psram_cs_limiter_control #(.NUM_BANKS(NUM_BANKS)) ctl (
    .clk(clk), .rstN(rstN), .accReq(accReq), .cntAtOne(cntAtOne),
    .limitOn(limitOn), .gapDone(gapDone), .bank(bank), .stb(stb),
    .csN(csN), .pause(pause), .resume(resume)
  );
endmodule

// File: rtl/psram_cs_limiter_checker.sv
module psram_cs_limiter_checker #(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 16,
  parameter int REG_W     = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [REG_W-1:0]     regRdata,
  input logic                 accReq,
  input logic [$clog2(NUM_BANKS)-1:0] accBank,
  input logic                 accSync,
  input logic [NUM_BANKS-1:0] csN,
  input logic                 pause,
  input logic                 resume
);
  localparam int BANK_W  = $clog2(NUM_BANKS);
  localparam int FIELD_W = CNT_W + NUM_BANKS;

  logic [CNT_W:0]       lowRun;
  logic [CNT_W-1:0]     capQ;
  logic                 limQ;
  logic [BANK_W-1:0]    lastBank, lowIdx, useBank;
  logic [NUM_BANKS-1:0] cfgEn;
  logic                 allHigh;

  assign allHigh = &csN;
  assign cfgEn   = regRdata[FIELD_W-1:CNT_W];
  assign useBank = pause ? lastBank : accBank;

  always_comb begin
    lowIdx = '0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (!csN[i]) lowIdx = BANK_W'(i);
  end

  // Independent pulse-width tracker built only from port values.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowRun   <= '0;
      capQ     <= '0;
      limQ     <= 1'b0;
      lastBank <= '0;
    end else if (allHigh) begin
      lowRun <= '0;
      capQ   <= regRdata[CNT_W-1:0];
      limQ   <= (regRdata[CNT_W-1:0] != '0) && cfgEn[useBank] && accSync;
    end else begin
      lastBank <= lowIdx;
      if (lowRun != '1) lowRun <= lowRun + 1'b1;
    end
  end

  a_r2_single_cs: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));
  a_r3_max_width: assert property (@(posedge clk) disable iff (!rstN)
    (limQ && !allHigh) |-> (lowRun < {1'b0, capQ}));
  a_r5_pause_cs_high: assert property (@(posedge clk) disable iff (!rstN)
    pause |-> allHigh);
  a_r5_resume_cs_low: assert property (@(posedge clk) disable iff (!rstN)
    resume |-> (!allHigh && !pause));
  a_r6_no_split_on_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pause) |-> $past(accReq));
  a_r8_no_resume_unrequested: assert property (@(posedge clk) disable iff (!rstN)
    resume |-> $past(accReq));
  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[REG_W-1:FIELD_W] == '0);
endmodule

bind psram_cs_limiter psram_cs_limiter_checker #(
  .NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W), .REG_W(REG_W)
) chk (
  .clk(clk), .rstN(rstN), .regRdata(regRdata), .accReq(accReq),
  .accBank(accBank), .accSync(accSync), .csN(csN), .pause(pause),
  .resume(resume)
);

// File: tb/psram_cs_limiter_test.sv
module psram_cs_limiter_test;
  localparam int MIN_GAP = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        accReq = 1'b0;
  logic [1:0]  accBank = '0;
  logic        accSync = 1'b1;
  logic [23:0] nextAddr = '0;
  logic [3:0]  csN;
  logic        pause, resume;
  logic [23:0] resumeAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  psram_cs_limiter #(.MIN_GAP(MIN_GAP)) uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .accReq(accReq), .accBank(accBank),
    .accSync(accSync), .nextAddr(nextAddr), .csN(csN), .pause(pause),
    .resume(resume), .resumeAddr(resumeAddr)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference model of the requirements, advanced at each rising edge.
  int          mPh = 0;
  int          mBank = 0, mCnt = 0, mGap = 0;
  bit          mLim = 0, mResume = 0;
  logic [23:0] mAddr = '0;
  logic [31:0] mReg = '0;

  function automatic bit limited(logic [31:0] r, int b, bit sync);
    return (r[15:0] != 0) && r[16+b] && sync;
  endfunction

  function automatic logic [3:0] expCs(int ph, int b);
    logic [3:0] v = 4'hF;
    if (ph == 1) v[b] = 1'b0;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPh <= 0; mReg <= '0; mResume <= 0; mCnt <= 0; mLim <= 0;
      mGap <= 0; mAddr <= '0; mBank <= 0;
    end else begin
      if (regWe) mReg <= regWdata & 32'h000F_FFFF;
      mResume <= 0;
      case (mPh)
        0: if (accReq) begin
          mPh <= 1; mBank <= accBank; mCnt <= mReg[15:0];
          mLim <= limited(mReg, accBank, accSync);
        end
        1: if (!accReq) mPh <= 0;
           else if (mLim && mCnt == 1) begin
             mPh <= 2; mGap <= MIN_GAP; mAddr <= nextAddr;
           end else if (mCnt != 0) mCnt <= mCnt - 1;
        default: if (mGap > 1) mGap <= mGap - 1;
           else if (accReq) begin
             mPh <= 1; mCnt <= mReg[15:0];
             mLim <= limited(mReg, mBank, accSync); mResume <= 1;
           end else mPh <= 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R2/R3/R9 csN vs model", 32'(csN), 32'(expCs(mPh, mBank)));
      check("R5 pause vs model", 32'(pause), 32'(mPh == 2));
      check("R5 resume vs model", 32'(resume), 32'(mResume));
      check("R5 resumeAddr vs model", 32'(resumeAddr), 32'(mAddr));
      check("R1 regRdata vs model", regRdata, mReg);
    end
  end

  task automatic wr(input logic [31:0] v);
    regWe = 1'b1; regWdata = v;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic measureLow(output int n);
    n = 0;
    while (csN != 4'hF) begin n++; @(negedge clk); end
  endtask

  task automatic measurePause(output int n);
    n = 0;
    while (pause) begin n++; @(negedge clk); end
  endtask

  task automatic idleFor(input int k);
    accReq = 1'b0;
    repeat (k) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n, pauses;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset regRdata", regRdata, 32'h0);
    check("R2 reset csN", 32'(csN), 32'hF);
    check("R5 reset pause", 32'(pause), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: unused bits read zero
    wr(32'hFFFF_FFFF);
    check("R1 field mask", regRdata, 32'h000F_FFFF);

    // R3/R5/R9: bank 2, limit 5
    wr(32'h0004_0005);
    accBank = 2'd2; accSync = 1'b1; nextAddr = 24'h001234; accReq = 1'b1;
    @(negedge clk);
    check("R9 one-cycle latency", 32'(csN), 32'hB);
    measureLow(n);
    check("R3 first pulse width", n, 5);
    measurePause(n);
    check("R5 gap length", n, MIN_GAP);
    check("R5 resume pulse", 32'(resume), 1);
    check("R5 resume address", 32'(resumeAddr), 32'h1234);
    check("R2 same bank after restart", 32'(csN), 32'hB);
    measureLow(n);
    check("R3 reload on restart", n, 5);
    // R8: abandon during the gap
    accReq = 1'b0;
    n = 0;
    repeat (6) begin @(negedge clk); if (resume || csN != 4'hF) n++; end
    check("R8 no restart after release", n, 0);

    // R6: release in the expiry cycle
    wr(32'h0001_0003);
    accBank = 2'd0; accReq = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 low on third cycle", 32'(csN), 32'hE);
    accReq = 1'b0;
    @(negedge clk);
    check("R6 cs high after release", 32'(csN), 32'hF);
    check("R6 no pause", 32'(pause), 0);
    @(negedge clk);
    check("R6 still no pause", 32'(pause), 0);

    // R4: disabled bank, zero limit, asynchronous access
    wr(32'h0002_0002);
    accBank = 2'd3; accReq = 1'b1;
    pauses = 0; n = 0;
    repeat (20) begin @(negedge clk); if (pause) pauses++; if (csN == 4'h7) n++; end
    check("R4 disabled bank never splits", pauses, 0);
    check("R4 disabled bank stays low", n, 20);
    idleFor(2);
    wr(32'h000F_0000);
    accBank = 2'd1; accReq = 1'b1;
    pauses = 0;
    repeat (20) begin @(negedge clk); if (pause) pauses++; end
    check("R4 zero limit never splits", pauses, 0);
    idleFor(2);
    wr(32'h000F_0002);
    accSync = 1'b0; accReq = 1'b1;
    pauses = 0;
    repeat (20) begin @(negedge clk); if (pause) pauses++; end
    check("R4 async never splits", pauses, 0);
    accSync = 1'b1;
    idleFor(2);

    // R7: write during a low period
    wr(32'h0002_0004);
    accBank = 2'd1; accReq = 1'b1;
    @(negedge clk);
    wr(32'h0002_000A);
    measureLow(n);
    check("R7 current pulse keeps old limit", n + 1, 4);
    measurePause(n);
    measureLow(n);
    check("R7 new limit after restart", n, 10);
    idleFor(3);

    // Random traffic checked against the model
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if ($urandom % 8 == 0) begin
        regWe = 1'b1;
        regWdata = {$urandom % 16'hFFFF, 16'h0} | 32'($urandom % 12);
      end else regWe = 1'b0;
      if ($urandom % 10 == 0) accReq = ~accReq;
      accBank  = 2'($urandom);
      accSync  = ($urandom % 6) != 0;
      nextAddr = 24'($urandom);
      @(negedge clk);
    end
    regWe = 1'b0;
    idleFor(4);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule